// File: doc/BRIEF.md
# Encrypted-Region Control Register Bank

This block is the register front end of an inline memory encryption unit. Software programs it over a simple 32-bit register bus that carries a privilege qualifier. It holds one DRAM region descriptor, which has an enable flag, an encrypt flag and lower and upper bounds at 64 KiB granularity. It also holds a 128-bit master key that software loads as 32-bit words and cannot read back. Three protection bits sit beside these: a key lock, a global lock and a privileged-only access bit.

A combinational lookup port classifies any 32-bit DRAM address as encrypted or bypass, using the programmed region. The cipher datapath reads the assembled key and the key-valid flag from dedicated outputs. A pin from the cipher side reports that the encryption hardware is disabled, and software reads it back in the status word.

Register byte offsets:

| Offset | Contents |
|---|---|
| 0x000 | control |
| 0x004 | status |
| 0x01C | access privilege |
| 0x040 | region flags |
| 0x044 | lower bound |
| 0x048 | upper bound |
| 0x200 to 0x20C | key words |
| 0x3F4 | version |
| 0x3F8 | identity |
| 0x3FC | size identity |

Top module: `enc_region_regs`

## Requirements
- R1: After reset every writable register, the lock bits, the key words and the key-valid flag are zero, and the lookup output is 0. Read data is combinational and is zero whenever no read is requested.
- R2: In the control word, bit 0 is the global lock and bit 1 is the key lock. Writing 1 sets a bit. Writing 0 never clears it, and only reset does.
- R3: While the global lock is set, writes to the control, access-privilege, region-flag and bound registers are ignored.
- R4: Key word i is written at offset 0x200+4*i and appears on `mkey_o` bits [32*i+31:32*i]. The key-valid flag (status bit 0) rises once each of the four words has been written since reset, and it stays set.
- R5: While the key lock is set, key-word writes are ignored.
- R6: Status bit 4 mirrors `enc_off_i`, status bit 0 is key-valid, and all other status bits read zero.
- R7: The region-flag register keeps bit 0 (enable) and bit 15 (encrypt). All of its other bits read zero.
- R8: The bound registers store written bits 31:16. A read returns those bits with bits 31:30 forced to zero and bits 15:0 zero.
- R9: With enable and encrypt both set, an address is classified encrypted exactly when lower[31:16] <= addr[31:16] <= upper[31:16]. This makes the upper bound inclusive through {upper,16'hFFFF}.
- R10: When enable or encrypt is clear, every address is classified bypass.
- R11: When access-privilege bit 0 is set, an unprivileged read returns zero and an unprivileged write is dropped. Privileged accesses are unaffected. With the bit clear, both kinds of access work.
- R12: Offset 0x3F4 reads {major[3:0],minor[3:0]} in bits 7:0, and 0x3F8 and 0x3FC read the identity and size-identity parameters.
- R13: Key words always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 10 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | 32 | Read data, same cycle |
| enc_off_i | input | 1 | Encryption hardware disabled |
| lk_addr | input | 32 | DRAM address to classify |
| lk_encrypt | output | 1 | 1 = encrypted, 0 = bypass |
| mkey_o | output | 128 | Master key, word 0 in the low bits |
| key_valid_o | output | 1 | All key words loaded |

## Verification
The bench builds the block with its default parameters: four key words, version 1.0, and the default identity constants. With four words, the key-valid flag can be reached after a partial load, and it can be checked that it stays low until the last word arrives. The full 16-bit bound width puts values with bits 31:30 set within reach, so the read masking can be checked against lookups that still use those bits. Random bounds, including inverted ones, are compared against a bench model at both edges of the window.

// File: rtl/encreg_pkg.sv
package encreg_pkg;

    localparam int DATA_W = 32;
    localparam int GRAN_W = 16;
    localparam int BND_W  = DATA_W - GRAN_W;
    localparam int OFF_W  = 10;

    localparam logic [OFF_W-1:0] OFF_CTRL = 10'h000;
    localparam logic [OFF_W-1:0] OFF_STAT = 10'h004;
    localparam logic [OFF_W-1:0] OFF_PRIV = 10'h01C;
    localparam logic [OFF_W-1:0] OFF_RCFG = 10'h040;
    localparam logic [OFF_W-1:0] OFF_RLO  = 10'h044;
    localparam logic [OFF_W-1:0] OFF_RHI  = 10'h048;
    localparam logic [OFF_W-1:0] OFF_KEY  = 10'h200;
    localparam logic [OFF_W-1:0] OFF_VER  = 10'h3F4;
    localparam logic [OFF_W-1:0] OFF_ID   = 10'h3F8;
    localparam logic [OFF_W-1:0] OFF_SIZE = 10'h3FC;

    localparam int CTRL_GLOCK_BIT = 0;
    localparam int CTRL_KLOCK_BIT = 1;
    localparam int STAT_KVAL_BIT  = 0;
    localparam int STAT_EOFF_BIT  = 4;
    localparam int RCFG_EN_BIT    = 0;
    localparam int RCFG_ENC_BIT   = 15;
    localparam int PRIV_ONLY_BIT  = 0;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_CTRL, SEL_STAT, SEL_PRIV, SEL_RCFG,
        SEL_RLO, SEL_RHI, SEL_KEY, SEL_VER, SEL_ID, SEL_SIZE
    } regsel_e;

    typedef struct packed {
        logic             en;
        logic             enc;
        logic [BND_W-1:0] lo;
        logic [BND_W-1:0] hi;
    } region_t;

    typedef struct packed {
        logic glock;
        logic klock;
        logic priv_only;
    } locks_t;

    function automatic regsel_e decode_off(input logic [OFF_W-1:0] off,
                                           input int key_words);
        if (int'(off) >= int'(OFF_KEY) &&
            int'(off) < int'(OFF_KEY) + 4 * key_words &&
            off[1:0] == 2'b00)
            return SEL_KEY;
        case (off)
            OFF_CTRL: return SEL_CTRL;
            OFF_STAT: return SEL_STAT;
            OFF_PRIV: return SEL_PRIV;
            OFF_RCFG: return SEL_RCFG;
            OFF_RLO:  return SEL_RLO;
            OFF_RHI:  return SEL_RHI;
            OFF_VER:  return SEL_VER;
            OFF_ID:   return SEL_ID;
            OFF_SIZE: return SEL_SIZE;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] bound_view(input logic [BND_W-1:0] b);
        return {2'b00, b[BND_W-3:0], {GRAN_W{1'b0}}};
    endfunction

    function automatic logic page_in_region(input region_t r,
                                            input logic [BND_W-1:0] page);
        return r.en && r.enc && (page >= r.lo) && (page <= r.hi);
    endfunction

endpackage

// File: rtl/encreg_lockctl.sv
module encreg_lockctl
    import encreg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_ok,
    input  regsel_e sel,
    input  logic    set_glock,
    input  logic    set_klock,
    input  logic    priv_bit,
    output locks_t  locks
);
    locks_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_ok && !q.glock) begin
            if (sel == SEL_CTRL) begin
                if (set_glock) q.glock <= 1'b1;
                if (set_klock) q.klock <= 1'b1;
            end
            if (sel == SEL_PRIV) q.priv_only <= priv_bit;
        end
    end

    assign locks = q;
endmodule

// File: rtl/encreg_region.sv
module encreg_region
    import encreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ok,
    input  logic             glock,
    input  regsel_e          sel,
    input  logic             cfg_en,
    input  logic             cfg_enc,
    input  logic [BND_W-1:0] bnd_in,
    input  logic [BND_W-1:0] lk_page,
    output region_t          rg,
    output logic             lk_hit
);
    region_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_ok && !glock) begin
            case (sel)
                SEL_RCFG: begin
                    q.en  <= cfg_en;
                    q.enc <= cfg_enc;
                end
                SEL_RLO: q.lo <= bnd_in;
                SEL_RHI: q.hi <= bnd_in;
                default: ;
            endcase
        end
    end

    assign rg     = q;
    assign lk_hit = page_in_region(q, lk_page);
endmodule

// File: rtl/encreg_keystore.sv
module encreg_keystore
    import encreg_pkg::*;
#(
    parameter int KEY_WORDS = 4,
    parameter int KIDX_W    = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_ok,
    input  logic                     klock,
    input  regsel_e                  sel,
    input  logic [KIDX_W-1:0]        idx,
    input  logic [DATA_W-1:0]        wdata,
    output logic [KEY_WORDS*DATA_W-1:0] key,
    output logic                     valid
);
    logic [KEY_WORDS-1:0][DATA_W-1:0] word_q;
    logic [KEY_WORDS-1:0]             seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            seen_q <= '0;
        end else if (wr_ok && !klock && sel == SEL_KEY) begin
            for (int i = 0; i < KEY_WORDS; i++) begin
                if (idx == KIDX_W'(i)) begin
                    word_q[i] <= wdata;
                    seen_q[i] <= 1'b1;
                end
            end
        end
    end

    assign key   = word_q;
    assign valid = &seen_q;
endmodule

// File: rtl/enc_region_regs.sv
module enc_region_regs
    import encreg_pkg::*;
#(
    parameter int          KEY_WORDS = 4,
    parameter logic [3:0]  VER_MAJOR = 4'd1,
    parameter logic [3:0]  VER_MINOR = 4'd0,
    parameter logic [31:0] ID_VALUE  = 32'h0051_A00C,
    parameter logic [31:0] SIZE_VALUE = 32'h5E1F_0A17
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_wr_en,
    input  logic                        bus_rd_en,
    input  logic [9:0]                  bus_addr,
    input  logic [31:0]                 bus_wdata,
    input  logic                        bus_priv,
    output logic [31:0]                 bus_rdata,
    input  logic                        enc_off_i,
    input  logic [31:0]                 lk_addr,
    output logic                        lk_encrypt,
    output logic [KEY_WORDS*32-1:0]     mkey_o,
    output logic                        key_valid_o
);
    localparam int KIDX_W = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1;

    regsel_e     sel;
    locks_t      locks;
    region_t     rg;
    logic        access_ok;
    logic        wr_ok;
    logic        rd_ok;
    logic        unused_lo;
    logic [KIDX_W-1:0] key_idx;

    assign sel       = decode_off(bus_addr, KEY_WORDS);
    assign access_ok = !locks.priv_only || bus_priv;
    assign wr_ok     = bus_wr_en && access_ok;
    assign rd_ok     = bus_rd_en && access_ok;
    assign key_idx   = bus_addr[KIDX_W+1:2];
    assign unused_lo = ^lk_addr[GRAN_W-1:0];

    encreg_lockctl u_lockctl (
        .clk       (clk),
        .rst       (rst),
        .wr_ok     (wr_ok),
        .sel       (sel),
        .set_glock (bus_wdata[CTRL_GLOCK_BIT]),
        .set_klock (bus_wdata[CTRL_KLOCK_BIT]),
        .priv_bit  (bus_wdata[PRIV_ONLY_BIT]),
        .locks     (locks)
    );

    encreg_region u_region (
        .clk     (clk),
        .rst     (rst),
        .wr_ok   (wr_ok),
        .glock   (locks.glock),
        .sel     (sel),
        .cfg_en  (bus_wdata[RCFG_EN_BIT]),
        .cfg_enc (bus_wdata[RCFG_ENC_BIT]),
        .bnd_in  (bus_wdata[DATA_W-1:GRAN_W]),
        .lk_page (lk_addr[DATA_W-1:GRAN_W]),
        .rg      (rg),
        .lk_hit  (lk_encrypt)
    );

    encreg_keystore #(
        .KEY_WORDS (KEY_WORDS),
        .KIDX_W    (KIDX_W)
    ) u_keys (
        .clk   (clk),
        .rst   (rst),
        .wr_ok (wr_ok),
        .klock (locks.klock),
        .sel   (sel),
        .idx   (key_idx),
        .wdata (bus_wdata),
        .key   (mkey_o),
        .valid (key_valid_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            case (sel)
                SEL_CTRL: begin
                    bus_rdata[CTRL_GLOCK_BIT] = locks.glock;
                    bus_rdata[CTRL_KLOCK_BIT] = locks.klock;
                end
                SEL_STAT: begin
                    bus_rdata[STAT_KVAL_BIT] = key_valid_o;
                    bus_rdata[STAT_EOFF_BIT] = enc_off_i;
                end
                SEL_PRIV: bus_rdata[PRIV_ONLY_BIT] = locks.priv_only;
                SEL_RCFG: begin
                    bus_rdata[RCFG_EN_BIT]  = rg.en;
                    bus_rdata[RCFG_ENC_BIT] = rg.enc;
                end
                SEL_RLO:  bus_rdata = bound_view(rg.lo);
                SEL_RHI:  bus_rdata = bound_view(rg.hi);
                SEL_VER:  bus_rdata = {24'h0, VER_MAJOR, VER_MINOR};
                SEL_ID:   bus_rdata = ID_VALUE;
                SEL_SIZE: bus_rdata = SIZE_VALUE;
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/encreg_chk.sv
module encreg_chk
    import encreg_pkg::*;
#(
    parameter int KEY_W = 128
) (
    input logic             clk,
    input logic             rst,
    input locks_t           locks,
    input region_t          rg,
    input logic [KEY_W-1:0] key_flat,
    input logic             key_valid,
    input logic             lk_encrypt,
    input logic             bus_rd_en,
    input logic             bus_priv,
    input logic [31:0]      bus_rdata
);
    // R2
    glock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        locks.glock |=> locks.glock);

    // R2
    klock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        locks.klock |=> locks.klock);

    // R3
    glock_region_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        locks.glock |=> $stable(rg));

    // R3
    glock_priv_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        locks.glock |=> $stable(locks.priv_only));

    // R5
    klock_key_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        locks.klock |=> ($stable(key_flat) && $stable(key_valid)));

    // R4
    kvalid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        key_valid |=> key_valid);

    // R10
    bypass_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !(rg.en && rg.enc) |-> !lk_encrypt);

    // R11
    unpriv_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (locks.priv_only && !bus_priv && bus_rd_en) |-> (bus_rdata == 32'h0));
endmodule

bind enc_region_regs encreg_chk #(.KEY_W(KEY_WORDS * 32)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .locks      (locks),
    .rg         (rg),
    .key_flat   (mkey_o),
    .key_valid  (key_valid_o),
    .lk_encrypt (lk_encrypt),
    .bus_rd_en  (bus_rd_en),
    .bus_priv   (bus_priv),
    .bus_rdata  (bus_rdata)
);

// File: tb/test_enc_region_regs.sv
module test_enc_region_regs;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_wr_en = 1'b0;
    logic         bus_rd_en = 1'b0;
    logic [9:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_priv = 1'b1;
    logic [31:0]  bus_rdata;
    logic         enc_off_i = 1'b0;
    logic [31:0]  lk_addr = '0;
    logic         lk_encrypt;
    logic [127:0] mkey_o;
    logic         key_valid_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    enc_region_regs i_enc_region_regs (
        .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_priv(bus_priv),
        .bus_rdata(bus_rdata), .enc_off_i(enc_off_i), .lk_addr(lk_addr),
        .lk_encrypt(lk_encrypt), .mkey_o(mkey_o), .key_valid_o(key_valid_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            fails = fails + 1;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d, input logic p);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = p;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_priv = 1'b1;
    endtask

    task automatic rd(input logic [9:0] a, input logic p, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a; bus_priv = p;
        #5 d = bus_rdata;
        bus_rd_en = 1'b0; bus_priv = 1'b1;
    endtask

    task automatic rdchk(input string tag, input logic [9:0] a, input logic p, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, p, d);
        chk(tag, {96'h0, d}, {96'h0, exp});
    endtask

    task automatic lkchk(input string tag, input logic [31:0] a, input logic exp);
        @(negedge clk);
        lk_addr = a;
        #5 chk(tag, {127'h0, lk_encrypt}, {127'h0, exp});
    endtask

    function automatic logic model_hit(input logic en, input logic enc,
                                       input logic [15:0] lo, input logic [15:0] hi,
                                       input logic [31:0] a);
        return en && enc && (a[31:16] >= lo) && (a[31:16] <= hi);
    endfunction

    function automatic logic [31:0] model_bound(input logic [31:0] w);
        return {2'b00, w[29:16], 16'h0};
    endfunction

    initial begin
        logic [31:0] d;
        void'($urandom(32'h0C0FFEE5));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rdchk("R1 ctrl", 10'h000, 1'b1, 32'h0);
        rdchk("R1 status", 10'h004, 1'b1, 32'h0);
        rdchk("R1 priv", 10'h01C, 1'b1, 32'h0);
        rdchk("R1 rcfg", 10'h040, 1'b1, 32'h0);
        rdchk("R1 lo", 10'h044, 1'b1, 32'h0);
        rdchk("R1 hi", 10'h048, 1'b1, 32'h0);
        lkchk("R1 lookup", 32'h0000_1234, 1'b0);
        @(negedge clk);
        bus_addr = 10'h3F8;
        #5 chk("R1 idle rdata", {96'h0, bus_rdata}, 128'h0);
        chk("R1 key", mkey_o, 128'h0);

        // R12 identity
        rdchk("R12 version", 10'h3F4, 1'b1, 32'h10);
        rdchk("R12 id", 10'h3F8, 1'b1, 32'h0051_A00C);
        rdchk("R12 size", 10'h3FC, 1'b1, 32'h5E1F_0A17);

        // R6 status mirrors pin
        enc_off_i = 1'b1;
        rdchk("R6 enc off", 10'h004, 1'b1, 32'h10);
        enc_off_i = 1'b0;
        rdchk("R6 enc on", 10'h004, 1'b1, 32'h0);

        // R8 bounds readback, R7 flags
        wr(10'h044, 32'hC012_3456, 1'b1);
        rdchk("R8 lo", 10'h044, 1'b1, 32'h0012_0000);
        wr(10'h048, 32'hC0FF_0000, 1'b1);
        rdchk("R8 hi", 10'h048, 1'b1, 32'h00FF_0000);
        wr(10'h040, 32'hFFFF_FFFF, 1'b1);
        rdchk("R7 rcfg", 10'h040, 1'b1, 32'h0000_8001);

        // R9 inclusive edges
        lkchk("R9 lo edge", 32'hC012_0000, 1'b1);
        lkchk("R9 below", 32'hC011_FFFF, 1'b0);
        lkchk("R9 hi edge", 32'hC0FF_FFFF, 1'b1);
        lkchk("R9 above", 32'hC100_0000, 1'b0);

        // R10 enable or encrypt clear
        wr(10'h040, 32'h0000_0001, 1'b1);
        lkchk("R10 enc clear", 32'hC050_0000, 1'b0);
        wr(10'h040, 32'h0000_8000, 1'b1);
        lkchk("R10 en clear", 32'hC050_0000, 1'b0);

        // R9 R10 R8 random
        for (int n = 0; n < 150; n++) begin
            logic [31:0] lo_w, hi_w, a;
            logic en, enc;
            int pick;
            lo_w = $urandom(); hi_w = $urandom();
            if ($urandom_range(0, 3) != 0 && lo_w[31:16] > hi_w[31:16]) begin
                a = lo_w; lo_w = hi_w; hi_w = a;
            end
            en = ($urandom_range(0, 4) != 0);
            enc = ($urandom_range(0, 4) != 0);
            wr(10'h044, lo_w, 1'b1);
            wr(10'h048, hi_w, 1'b1);
            wr(10'h040, {16'h0, enc, 14'h0, en}, 1'b1);
            if (n % 10 == 0) begin
                rdchk("R8 rand lo", 10'h044, 1'b1, model_bound(lo_w));
                rdchk("R8 rand hi", 10'h048, 1'b1, model_bound(hi_w));
            end
            for (int k = 0; k < 4; k++) begin
                pick = $urandom_range(0, 4);
                a = $urandom();
                case (pick)
                    0: a[31:16] = lo_w[31:16];
                    1: a[31:16] = lo_w[31:16] - 16'd1;
                    2: a[31:16] = hi_w[31:16];
                    3: a[31:16] = hi_w[31:16] + 16'd1;
                    default: ;
                endcase
                lkchk("R9 R10 rand lookup", a,
                      model_hit(en, enc, lo_w[31:16], hi_w[31:16], a));
            end
        end

        // fixed region for later steps
        wr(10'h044, 32'hC012_0000, 1'b1);
        wr(10'h048, 32'hC0FF_0000, 1'b1);
        wr(10'h040, 32'h0000_8001, 1'b1);

        // R11 privilege
        rdchk("R11 open unpriv read", 10'h040, 1'b0, 32'h8001);
        wr(10'h01C, 32'h1, 1'b1);
        rdchk("R11 priv bit", 10'h01C, 1'b1, 32'h1);
        rdchk("R11 unpriv read zero", 10'h040, 1'b0, 32'h0);
        wr(10'h040, 32'h0, 1'b0);
        rdchk("R11 unpriv write dropped", 10'h040, 1'b1, 32'h8001);
        lkchk("R11 lookup intact", 32'hC050_0000, 1'b1);
        wr(10'h01C, 32'h0, 1'b1);
        rdchk("R11 reopened", 10'h040, 1'b0, 32'h8001);

        // R4 key load, R13 unreadable
        wr(10'h200, 32'h1111_AAAA, 1'b1);
        wr(10'h204, 32'h2222_BBBB, 1'b1);
        wr(10'h208, 32'h3333_CCCC, 1'b1);
        rdchk("R4 partial not valid", 10'h004, 1'b1, 32'h0);
        rdchk("R13 key read zero", 10'h204, 1'b1, 32'h0);
        wr(10'h20C, 32'h4444_DDDD, 1'b1);
        rdchk("R4 valid", 10'h004, 1'b1, 32'h1);
        chk("R4 key", mkey_o, 128'h4444_DDDD_3333_CCCC_2222_BBBB_1111_AAAA);
        chk("R4 valid pin", {127'h0, key_valid_o}, 128'h1);
        wr(10'h208, 32'h5555_EEEE, 1'b1);
        chk("R4 rewrite", mkey_o, 128'h4444_DDDD_5555_EEEE_2222_BBBB_1111_AAAA);

        // R2 set-only, R5 key lock
        wr(10'h000, 32'h2, 1'b1);
        rdchk("R2 klock set", 10'h000, 1'b1, 32'h2);
        wr(10'h000, 32'h0, 1'b1);
        rdchk("R2 klock kept", 10'h000, 1'b1, 32'h2);
        wr(10'h200, 32'hDEAD_BEEF, 1'b1);
        chk("R5 key frozen", mkey_o, 128'h4444_DDDD_5555_EEEE_2222_BBBB_1111_AAAA);

        // R3 global lock
        wr(10'h000, 32'h1, 1'b1);
        rdchk("R2 glock set", 10'h000, 1'b1, 32'h3);
        wr(10'h040, 32'h0, 1'b1);
        rdchk("R3 rcfg frozen", 10'h040, 1'b1, 32'h8001);
        wr(10'h044, 32'hC500_0000, 1'b1);
        rdchk("R3 lo frozen", 10'h044, 1'b1, 32'h0012_0000);
        wr(10'h01C, 32'h1, 1'b1);
        rdchk("R3 priv frozen", 10'h01C, 1'b0, 32'h0);
        lkchk("R3 lookup kept", 32'hC050_0000, 1'b1);
        enc_off_i = 1'b1;
        rdchk("R6 locked status", 10'h004, 1'b1, 32'h11);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule